// File: doc/BRIEF.md
# Fused Multiword Carry Sequencer

This block runs two fused multiword-arithmetic operations straight against its own 32-entry, 64-bit register file. The operations are add-with-carry and subtract-with-borrow. Each one is a fixed chain of five read-modify-write steps. The chain uses the source registers as scratch space, so every step sees what the steps before it left behind. The final carry or borrow ends up in the register named by the first source index. Because of this, indices that alias one another change the result, and the block reproduces that effect exactly.

A caller selects the operation, gives four register indices (destination, first source, second source, third source) and pulses a start strobe. The sequencer then commits exactly one register write per cycle. While it runs, it shows each write on an observation port. A one-cycle done pulse marks the end of the operation. The register file has a host load port and a combinational peek port, so the block can be preloaded and inspected on its own.

Top module: `mwc_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `done_o` and `wr_en_o` are 0 and every register reads 0 through the peek port.
- R2: With `op_sel_i`=0 (add-with-carry), the five steps are, in order:
  - D = D + A
  - A = (D <u A)
  - D = D + B
  - B = (D <u B)
  - A = A | B

  D, A and B are the registers named by `idx_d_i`, `idx_a_i` and `idx_b_i`. `<u` is an unsigned compare that yields 0 or 1.
- R3: With `op_sel_i`=1 (subtract-with-borrow), the five steps are, in order:
  - A = D - A
  - C = (D <u A)
  - D = A - B
  - B = (A <u D)
  - A = B | C

  C is the register named by `idx_c_i`.
- R4: Every step reads the register contents left by the previous step, including when two or more indices name the same register.
- R5: Register 0 always reads 0. A write aimed at it, either from a step or from the host port, is discarded.
- R6: A start accepted while idle raises `busy_o` from the next cycle for exactly five cycles. `done_o` is high for exactly one cycle, the cycle right after the fifth write, and in that cycle `busy_o` is already 0.
- R7: In each busy cycle, `wr_en_o`=1 and `wr_idx_o`/`wr_data_o` show the write that commits at the next clock edge, even when the target is register 0. When idle, `wr_en_o`=0.
- R8: A start pulse that arrives while busy is ignored. The running operation keeps its latched operation and indices, and no second operation follows it.
- R9: The host load port writes one register per cycle while idle and is ignored while busy. `peek_data_o` returns the current contents of register `peek_idx_i` in the same cycle.
- R10: The operation select is encoded as 0 for add-with-carry and 1 for subtract-with-borrow. It is sampled only together with an accepted start.
- R11: All additions and subtractions wrap modulo 2^64. For example, adding 2 to 0xFFFF_FFFF_FFFF_FFFF gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| op_sel_i | input | 1 | 0 add-with-carry, 1 subtract-with-borrow |
| idx_d_i | input | 5 | Destination register index |
| idx_a_i | input | 5 | First source index (receives the carry/borrow) |
| idx_b_i | input | 5 | Second source index |
| idx_c_i | input | 5 | Third source index (used by subtract-with-borrow) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wr_en_o | output | 1 | A step write commits at the next edge |
| wr_idx_o | output | 5 | Target index of that write |
| wr_data_o | output | 64 | Value of that write |
| ld_en_i | input | 1 | Host load strobe, honoured only while idle |
| ld_idx_i | input | 5 | Host load index |
| ld_data_i | input | 64 | Host load value |
| peek_idx_i | input | 5 | Peek read index |
| peek_data_o | output | 64 | Contents of the peeked register |

## Verification
The embedded properties take for granted that reset is held for at least one clock edge before any start. They also assume the latched command is the only source of step indices, so the properties on step advance and command stability hold only if nothing outside the sequencer writes the file while it runs. The stimulus keeps to this: it loads registers only through the host port, and it deliberately drives that port and the start strobe during a busy window only to show that both are refused. The vectors cover plain, carrying, borrowing, aliased and zero-register index sets. A reference model applies the five steps in order, so aliasing effects come out of the model rather than being tabulated by hand.

// File: rtl/mwc_pkg.sv
// Shared types for the fused multiword carry sequencer.
// Holds the operation encoding, the per-step recipe and the step table.
package mwc_pkg;

    localparam int NSTEP = 5;
    localparam int STEPW = $clog2(NSTEP);

    typedef enum logic {
        OP_ADDC = 1'b0,
        OP_SUBB = 1'b1
    } op_e;

    // Which latched index a step operand or destination refers to
    typedef enum logic [1:0] {
        ROLE_D = 2'd0,
        ROLE_A = 2'd1,
        ROLE_B = 2'd2,
        ROLE_C = 2'd3
    } role_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_LTU = 2'd2,
        FN_OR  = 2'd3
    } fn_e;

    typedef struct packed {
        role_e dst;
        role_e x;
        role_e y;
        fn_e   fn;
    } step_t;

    // Recipe for step s of operation op: dst = fn(x, y)
    function automatic step_t step_lookup(op_e op, logic [STEPW-1:0] s);
        step_t t;
        t = '{dst: ROLE_D, x: ROLE_D, y: ROLE_D, fn: FN_OR};
        if (op == OP_ADDC) begin
            case (s)
                3'd0:    t = '{dst: ROLE_D, x: ROLE_D, y: ROLE_A, fn: FN_ADD};
                3'd1:    t = '{dst: ROLE_A, x: ROLE_D, y: ROLE_A, fn: FN_LTU};
                3'd2:    t = '{dst: ROLE_D, x: ROLE_D, y: ROLE_B, fn: FN_ADD};
                3'd3:    t = '{dst: ROLE_B, x: ROLE_D, y: ROLE_B, fn: FN_LTU};
                3'd4:    t = '{dst: ROLE_A, x: ROLE_A, y: ROLE_B, fn: FN_OR};
                default: t = '{dst: ROLE_D, x: ROLE_D, y: ROLE_D, fn: FN_OR};
            endcase
        end else begin
            case (s)
                3'd0:    t = '{dst: ROLE_A, x: ROLE_D, y: ROLE_A, fn: FN_SUB};
                3'd1:    t = '{dst: ROLE_C, x: ROLE_D, y: ROLE_A, fn: FN_LTU};
                3'd2:    t = '{dst: ROLE_D, x: ROLE_A, y: ROLE_B, fn: FN_SUB};
                3'd3:    t = '{dst: ROLE_B, x: ROLE_A, y: ROLE_D, fn: FN_LTU};
                3'd4:    t = '{dst: ROLE_A, x: ROLE_B, y: ROLE_C, fn: FN_OR};
                default: t = '{dst: ROLE_D, x: ROLE_D, y: ROLE_D, fn: FN_OR};
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/mwc_regfile.sv
// Register file with one write port and NRD combinational read ports.
// Entry 0 is never written and so always reads zero.
// Assumes: reset held for at least one edge before use.
module mwc_regfile #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    parameter int NRD  = 3,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [IDXW-1:0] widx_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic [IDXW-1:0] rd_idx_i  [NRD],
    output logic [XLEN-1:0] rd_data_o [NRD]
);

    logic [XLEN-1:0] mem [NREG];

    // Storage update: clear on reset, skip writes aimed at entry 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= '0;
            end
        end else if (we_i && (widx_i != '0)) begin
            mem[widx_i] <= wdata_i;
        end
    end

    // Read ports: plain combinational lookup, one per requester
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data_o[g] = mem[rd_idx_i[g]];
    end

    AST_X0_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem[0] == '0); // R5

endmodule

// File: rtl/mwc_ctrl.sv
// Sequencer control: accepts a start while idle, latches the command,
// walks NSTEP steps (one write each) and pulses done afterwards.
// Assumes: start and command inputs are valid in the cycle start is high.
module mwc_ctrl
    import mwc_pkg::*;
#(
    parameter int IDXW = 5,
    localparam logic [STEPW-1:0] LAST = STEPW'(NSTEP - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  op_e              op_i,
    input  logic [IDXW-1:0]  idx_d_i,
    input  logic [IDXW-1:0]  idx_a_i,
    input  logic [IDXW-1:0]  idx_b_i,
    input  logic [IDXW-1:0]  idx_c_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [STEPW-1:0] step_o,
    output op_e              op_o,
    output logic [IDXW-1:0]  idx_d_o,
    output logic [IDXW-1:0]  idx_a_o,
    output logic [IDXW-1:0]  idx_b_o,
    output logic [IDXW-1:0]  idx_c_o
);

    logic             busy_q;
    logic             done_q;
    logic [STEPW-1:0] step_q;
    op_e              op_q;
    logic [IDXW-1:0]  idx_d_q, idx_a_q, idx_b_q, idx_c_q;

    // Command latch and step counter; starts while busy fall through
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            step_q  <= '0;
            op_q    <= OP_ADDC;
            idx_d_q <= '0;
            idx_a_q <= '0;
            idx_b_q <= '0;
            idx_c_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q  <= 1'b1;
                    step_q  <= '0;
                    op_q    <= op_i;
                    idx_d_q <= idx_d_i;
                    idx_a_q <= idx_a_i;
                    idx_b_q <= idx_b_i;
                    idx_c_q <= idx_c_i;
                end
            end else if (step_q == LAST) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                step_q <= '0;
            end else begin
                step_q <= step_q + STEPW'(1);
            end
        end
    end

    assign busy_o  = busy_q;
    assign done_o  = done_q;
    assign step_o  = step_q;
    assign op_o    = op_q;
    assign idx_d_o = idx_d_q;
    assign idx_a_o = idx_a_q;
    assign idx_b_o = idx_b_q;
    assign idx_c_o = idx_c_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R6
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q))); // R6
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (step_q <= LAST)); // R6
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && step_q != LAST) |=> (busy_q && step_q == $past(step_q) + STEPW'(1))); // R6
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(op_q) && $stable(idx_d_q) && $stable(idx_a_q)
                                       && $stable(idx_b_q) && $stable(idx_c_q))); // R8

endmodule

// File: rtl/mwc_step_decode.sv
// Translates (operation, step) into destination and operand indices
// and the arithmetic function, using the latched register indices.
// Assumes: step is within range whenever the result is used.
module mwc_step_decode
    import mwc_pkg::*;
#(
    parameter int IDXW = 5
) (
    input  op_e              op_i,
    input  logic [STEPW-1:0] step_i,
    input  logic [IDXW-1:0]  idx_d_i,
    input  logic [IDXW-1:0]  idx_a_i,
    input  logic [IDXW-1:0]  idx_b_i,
    input  logic [IDXW-1:0]  idx_c_i,
    output logic [IDXW-1:0]  dst_idx_o,
    output logic [IDXW-1:0]  x_idx_o,
    output logic [IDXW-1:0]  y_idx_o,
    output fn_e              fn_o
);

    step_t rec;

    function automatic logic [IDXW-1:0] pick(role_e r, logic [IDXW-1:0] d,
                                              logic [IDXW-1:0] a, logic [IDXW-1:0] b,
                                              logic [IDXW-1:0] c);
        case (r)
            ROLE_D:  return d;
            ROLE_A:  return a;
            ROLE_B:  return b;
            default: return c;
        endcase
    endfunction

    // Look up the recipe and resolve its roles to concrete indices
    always_comb begin
        rec       = step_lookup(op_i, step_i);
        dst_idx_o = pick(rec.dst, idx_d_i, idx_a_i, idx_b_i, idx_c_i);
        x_idx_o   = pick(rec.x,   idx_d_i, idx_a_i, idx_b_i, idx_c_i);
        y_idx_o   = pick(rec.y,   idx_d_i, idx_a_i, idx_b_i, idx_c_i);
        fn_o      = rec.fn;
    end

endmodule

// File: rtl/mwc_step_alu.sv
// One-step arithmetic: wrapping add, wrapping subtract,
// unsigned less-than (0/1) and bitwise OR.
// Assumes: nothing beyond valid operands.
module mwc_step_alu
    import mwc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  fn_e             fn_i,
    input  logic [XLEN-1:0] x_i,
    input  logic [XLEN-1:0] y_i,
    output logic [XLEN-1:0] res_o
);

    // Function select; add and subtract drop the carry out
    always_comb begin
        case (fn_i)
            FN_ADD:  res_o = x_i + y_i;
            FN_SUB:  res_o = x_i - y_i;
            FN_LTU:  res_o = {{(XLEN-1){1'b0}}, (x_i < y_i)};
            default: res_o = x_i | y_i;
        endcase
    end

endmodule

// File: rtl/mwc_seq.sv
// Top of the fused multiword carry sequencer. Joins control, step
// decode, step arithmetic and the register file. Step writes own the
// file's write port while busy; host loads use it only while idle.
// Assumes: synchronous active-low reset before the first start.
module mwc_seq
    import mwc_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            op_sel_i,
    input  logic [IDXW-1:0] idx_d_i,
    input  logic [IDXW-1:0] idx_a_i,
    input  logic [IDXW-1:0] idx_b_i,
    input  logic [IDXW-1:0] idx_c_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            wr_en_o,
    output logic [IDXW-1:0] wr_idx_o,
    output logic [XLEN-1:0] wr_data_o,
    input  logic            ld_en_i,
    input  logic [IDXW-1:0] ld_idx_i,
    input  logic [XLEN-1:0] ld_data_i,
    input  logic [IDXW-1:0] peek_idx_i,
    output logic [XLEN-1:0] peek_data_o
);

    localparam int NRD = 3;

    logic             busy;
    logic             done;
    logic [STEPW-1:0] step;
    op_e              op_q;
    logic [IDXW-1:0]  lat_d, lat_a, lat_b, lat_c;
    logic [IDXW-1:0]  dst_idx, x_idx, y_idx;
    fn_e              fn;
    logic [XLEN-1:0]  step_res;
    logic [IDXW-1:0]  rd_idx  [NRD];
    logic [XLEN-1:0]  rd_data [NRD];
    logic             rf_we;
    logic [IDXW-1:0]  rf_widx;
    logic [XLEN-1:0]  rf_wdata;

    mwc_ctrl #(.IDXW(IDXW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_i    (op_e'(op_sel_i)),
        .idx_d_i (idx_d_i),
        .idx_a_i (idx_a_i),
        .idx_b_i (idx_b_i),
        .idx_c_i (idx_c_i),
        .busy_o  (busy),
        .done_o  (done),
        .step_o  (step),
        .op_o    (op_q),
        .idx_d_o (lat_d),
        .idx_a_o (lat_a),
        .idx_b_o (lat_b),
        .idx_c_o (lat_c)
    );

    mwc_step_decode #(.IDXW(IDXW)) u_dec (
        .op_i      (op_q),
        .step_i    (step),
        .idx_d_i   (lat_d),
        .idx_a_i   (lat_a),
        .idx_b_i   (lat_b),
        .idx_c_i   (lat_c),
        .dst_idx_o (dst_idx),
        .x_idx_o   (x_idx),
        .y_idx_o   (y_idx),
        .fn_o      (fn)
    );

    mwc_step_alu #(.XLEN(XLEN)) u_alu (
        .fn_i  (fn),
        .x_i   (rd_data[0]),
        .y_i   (rd_data[1]),
        .res_o (step_res)
    );

    // Read-port assignment: two step operands, one peek
    always_comb begin
        rd_idx[0] = x_idx;
        rd_idx[1] = y_idx;
        rd_idx[2] = peek_idx_i;
    end

    // Write-port arbitration: running step first, host load only when idle
    always_comb begin
        if (busy) begin
            rf_we    = 1'b1;
            rf_widx  = dst_idx;
            rf_wdata = step_res;
        end else begin
            rf_we    = ld_en_i;
            rf_widx  = ld_idx_i;
            rf_wdata = ld_data_i;
        end
    end

    mwc_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (rf_we),
        .widx_i    (rf_widx),
        .wdata_i   (rf_wdata),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );

    assign busy_o      = busy;
    assign done_o      = done;
    assign wr_en_o     = busy;
    assign wr_idx_o    = dst_idx;
    assign wr_data_o   = step_res;
    assign peek_data_o = rd_data[2];

    AST_LTU_IS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fn == FN_LTU) |-> (step_res[XLEN-1:1] == '0)); // R2
    AST_NO_START_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6

endmodule

// File: tb/mwc_seq_tb.sv
module mwc_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_sel_i = 1'b0;
    logic [4:0]  idx_d_i = '0, idx_a_i = '0, idx_b_i = '0, idx_c_i = '0;
    logic        busy_o, done_o, wr_en_o;
    logic [4:0]  wr_idx_o;
    logic [63:0] wr_data_o;
    logic        ld_en_i = 1'b0;
    logic [4:0]  ld_idx_i = '0;
    logic [63:0] ld_data_i = '0;
    logic [4:0]  peek_idx_i = '0;
    logic [63:0] peek_data_o;

    always #10 clk = ~clk;

    mwc_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_sel_i(op_sel_i),
        .idx_d_i(idx_d_i), .idx_a_i(idx_a_i), .idx_b_i(idx_b_i), .idx_c_i(idx_c_i),
        .busy_o(busy_o), .done_o(done_o), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
        .wr_data_o(wr_data_o), .ld_en_i(ld_en_i), .ld_idx_i(ld_idx_i),
        .ld_data_i(ld_data_i), .peek_idx_i(peek_idx_i), .peek_data_o(peek_data_o)
    );

    typedef struct packed {
        bit        op;
        bit [4:0]  d, a, b, c;
        bit [63:0] vd, va, vb, vc;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 5'd5,  5'd6,  5'd7,  5'd8,  64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd3, 64'd0},
        '{1'b0, 5'd10, 5'd11, 5'd12, 5'd13, 64'd10, 64'd20, 64'd30, 64'd0},
        '{1'b0, 5'd1,  5'd2,  5'd3,  5'd4,  64'd1, 64'd1, 64'hFFFF_FFFF_FFFF_FFFE, 64'd7},
        '{1'b1, 5'd14, 5'd15, 5'd16, 5'd17, 64'd100, 64'd30, 64'd50, 64'd9},
        '{1'b1, 5'd5,  5'd6,  5'd7,  5'd8,  64'd5, 64'd10, 64'd0, 64'd9},
        '{1'b0, 5'd4,  5'd4,  5'd9,  5'd2,  64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 64'd5, 64'd1},
        '{1'b1, 5'd18, 5'd19, 5'd20, 5'd19, 64'd7, 64'd3, 64'd1, 64'd3},
        '{1'b0, 5'd22, 5'd23, 5'd0,  5'd24, 64'hFFFF_FFFF_0000_0000, 64'h1_0000_0000, 64'd44, 64'd1},
        '{1'b1, 5'd25, 5'd26, 5'd27, 5'd0,  64'd3, 64'd9, 64'd2, 64'd0},
        '{1'b0, 5'd3,  5'd3,  5'd3,  5'd3,  64'h7, 64'h7, 64'h7, 64'h7}
    };

    int total = 0;
    int bad = 0;
    logic [63:0] m [32];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rv(input logic [4:0] i);
        return (i == 5'd0) ? 64'd0 : m[i];
    endfunction

    // Reference: apply step s of the selected operation to the model (R2, R3, R4, R5)
    task automatic mstep(input bit op, input int s, input logic [4:0] d, a, b, c,
                         output logic [4:0] wi, output logic [63:0] wv);
        wi = 5'd0;
        wv = 64'd0;
        if (!op) begin
            case (s)
                1: begin wi = d; wv = rv(d) + rv(a); end
                2: begin wi = a; wv = {63'd0, rv(d) < rv(a)}; end
                3: begin wi = d; wv = rv(d) + rv(b); end
                4: begin wi = b; wv = {63'd0, rv(d) < rv(b)}; end
                5: begin wi = a; wv = rv(a) | rv(b); end
                default: ;
            endcase
        end else begin
            case (s)
                1: begin wi = a; wv = rv(d) - rv(a); end
                2: begin wi = c; wv = {63'd0, rv(d) < rv(a)}; end
                3: begin wi = d; wv = rv(a) - rv(b); end
                4: begin wi = b; wv = {63'd0, rv(a) < rv(d)}; end
                5: begin wi = a; wv = rv(b) | rv(c); end
                default: ;
            endcase
        end
        if (wi != 5'd0) m[wi] = wv;
    endtask

    task automatic host_write(input logic [4:0] i, input logic [63:0] v);
        ld_en_i = 1'b1;
        ld_idx_i = i;
        ld_data_i = v;
        @(negedge clk);
        ld_en_i = 1'b0;
        if (i != 5'd0) m[i] = v;
    endtask

    task automatic peek_chk(input logic [4:0] i, input string tag);
        peek_idx_i = i;
        #1;
        chk(peek_data_o == rv(i), tag, peek_data_o, rv(i));
    endtask

    task automatic run_op(input vec_t v, input bit disturb);
        string tag;
        logic [4:0]  wi;
        logic [63:0] wv;
        bit alias_set;
        alias_set = (v.d == v.a) || (v.d == v.b) || (v.a == v.b) ||
                    (v.op && ((v.c == v.a) || (v.c == v.b) || (v.c == v.d)));
        if (alias_set) tag = "R4 alias";
        else if (v.d == 0 || v.a == 0 || v.b == 0 || (v.op && v.c == 0)) tag = "R5 x0";
        else tag = v.op ? "R3/R10 subb" : "R2/R10 addc";
        host_write(v.d, v.vd);
        host_write(v.a, v.va);
        host_write(v.b, v.vb);
        host_write(v.c, v.vc);
        op_sel_i = v.op;
        idx_d_i = v.d; idx_a_i = v.a; idx_b_i = v.b; idx_c_i = v.c;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int s = 1; s <= 5; s++) begin
            chk(busy_o == 1'b1, "R6 busy during step", {63'd0, busy_o}, 64'd1);
            chk(wr_en_o == 1'b1, "R7 write enable", {63'd0, wr_en_o}, 64'd1);
            mstep(v.op, s, v.d, v.a, v.b, v.c, wi, wv);
            chk(wr_idx_o == wi, {tag, " R7 write index"}, {59'd0, wr_idx_o}, {59'd0, wi});
            chk(wr_data_o == wv, {tag, " step value"}, wr_data_o, wv);
            if (disturb && s == 2) begin
                // R8: a start and new command while busy; R9: host load while busy
                start_i = 1'b1;
                op_sel_i = ~v.op;
                idx_d_i = 5'd21; idx_a_i = 5'd21; idx_b_i = 5'd21; idx_c_i = 5'd21;
                ld_en_i = 1'b1; ld_idx_i = 5'd21; ld_data_i = 64'hDEAD_BEEF;
            end else begin
                start_i = 1'b0;
                ld_en_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        ld_en_i = 1'b0;
        chk(done_o == 1'b1, "R6 done after fifth write", {63'd0, done_o}, 64'd1);
        chk(busy_o == 1'b0, "R6 idle at done", {63'd0, busy_o}, 64'd0);
        chk(wr_en_o == 1'b0, "R7 no write when idle", {63'd0, wr_en_o}, 64'd0);
        @(negedge clk);
        chk(done_o == 1'b0, "R6 done one cycle", {63'd0, done_o}, 64'd0);
        chk(busy_o == 1'b0, "R8 no second run", {63'd0, busy_o}, 64'd0);
        peek_chk(v.d, {tag, " final D"});
        peek_chk(v.a, {tag, " final A"});
        peek_chk(v.b, {tag, " final B"});
        peek_chk(v.c, {tag, " final C"});
        peek_chk(5'd0, "R5 x0 reads zero");
        if (disturb) peek_chk(5'd21, "R9 load ignored while busy");
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m[i] = 64'd0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy_o == 1'b0, "R1 busy at reset", {63'd0, busy_o}, 64'd0);
        chk(done_o == 1'b0, "R1 done at reset", {63'd0, done_o}, 64'd0);
        chk(wr_en_o == 1'b0, "R1 wr_en at reset", {63'd0, wr_en_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        peek_chk(5'd7, "R1 register cleared");
        peek_chk(5'd31, "R1 register cleared");

        // R9/R5: host load and peek, load to x0 discarded
        host_write(5'd21, 64'h1234_5678_9ABC_DEF0);
        peek_chk(5'd21, "R9 host load");
        host_write(5'd0, 64'hFFFF);
        peek_chk(5'd0, "R5 host write to x0");

        for (int k = 0; k < NVEC; k++) begin
            run_op(VECS[k], k == 3);
            if (k == 0) begin
                // R11: max + 2 wraps to 1, then + 3 gives 4, carry 1 kept in A
                peek_idx_i = 5'd5; #1;
                chk(peek_data_o == 64'd4, "R11 wrap add D", peek_data_o, 64'd4);
                peek_idx_i = 5'd6; #1;
                chk(peek_data_o == 64'd1, "R2 carry in A", peek_data_o, 64'd1);
            end
            if (k == 4) begin
                // R11: 5 - 10 wraps, borrow 1 left in A
                peek_idx_i = 5'd5; #1;
                chk(peek_data_o == 64'hFFFF_FFFF_FFFF_FFFB, "R11 wrap sub D", peek_data_o,
                    64'hFFFF_FFFF_FFFF_FFFB);
                peek_idx_i = 5'd6; #1;
                chk(peek_data_o == 64'd1, "R3 borrow in A", peek_data_o, 64'd1);
            end
        end

        // R1: reset in the middle of a run clears state and registers
        host_write(5'd9, 64'd77);
        op_sel_i = 1'b0; idx_d_i = 5'd9; idx_a_i = 5'd10; idx_b_i = 5'd11; idx_c_i = 5'd12;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) m[i] = 64'd0;
        chk(busy_o == 1'b0, "R1 busy after mid-run reset", {63'd0, busy_o}, 64'd0);
        chk(done_o == 1'b0, "R1 done after mid-run reset", {63'd0, done_o}, 64'd0);
        peek_chk(5'd9, "R1 register cleared by reset");
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 stays idle", {63'd0, busy_o}, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule